// File: doc/BRIEF.md
# Paged Word Register Bridge for a PHY Management Bus

This block lets a management bus master that only speaks 16-bit PHY register transactions reach a 32-bit internal register space. It answers at a single reserved PHY address; every request to any other PHY address is left alone. A page register holds the upper internal address bits. A group of sixteen registers picks the word inside the current page and carries the low half of that word. One further register carries the high half.

Writing a word takes three accesses: the page, then the low half, then the high half. The low half is only staged. The full 32-bit write goes onto the internal bus when the high half arrives. Reading a word is also three accesses: the page, then a read of the low half, then a read of the high-half register. The low-half read fetches the whole word. It returns the low half and latches the high half, so the later read of the high-half register gives the other half of the same word.

The block takes requests that are already decoded (PHY address, register number, data) and drives a word-aligned internal register bus with a byte address. A small internal register file sits on that bus as the responder, so the bridge can be exercised on its own.

Top module: `mdio_page_bridge`

## Requirements
- R1: Requests whose PHY address differs from the bridge address (default 0x1F) are ignored. They cause no internal bus cycle, no response, and no change to the page or staged data.
- R2: A write to register 0x1F loads the page from data bits 9:0; data bits 15:10 are discarded. A read of register 0x1F returns the page, zero-extended to 16 bits.
- R3: A write to register 0..15 stores the low half and the word index (the register number) in staging. It starts no internal bus cycle.
- R4: A write to register 0x10 starts exactly one internal write cycle in the following cycle. Its byte address is {page, staged index, 2'b00} and its data is {written data, staged low half}.
- R5: A read of register 0..15 starts one internal read cycle in the following cycle, at byte address {page, register number, 2'b00}. The response carries bits 15:0 of the word read.
- R6: A read of register 0x10 returns bits 31:16 of the word fetched by the latest low-half read. Internal writes made after that fetch do not change it. The value is 0 after reset.
- R7: Every internal bus address has bits 1:0 equal to zero.
- R8: Reads of registers 0x11..0x1E return 0. Writes to them have no effect and start no bus cycle.
- R9: After reset the page is 0, no response is valid and no internal bus cycle is active.
- R10: The internal register file holds 2^RF_AW words at byte addresses 0 to 4*2^RF_AW-1. A read outside that window returns 0, and a write outside it is dropped.
- R11: A read request at the bridge address gives exactly one response, valid for one cycle, two clock edges after the request is sampled. Write requests give no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Decoded management request present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_phy_i | input | 5 | PHY address of the request |
| req_reg_i | input | 5 | Register number of the request |
| req_wdata_i | input | 16 | Write data |
| rsp_valid_o | output | 1 | Read response valid (one-cycle pulse) |
| rsp_rdata_o | output | 16 | Read response data |
| bus_req_o | output | 1 | Internal bus cycle active |
| bus_we_o | output | 1 | Internal bus cycle is a write |
| bus_addr_o | output | 16 | Internal byte address |
| bus_wdata_o | output | 32 | Internal write data |

## Verification
The bench uses the default parameters: a 10-bit page, bridge address 0x1F and a 32-word register file. With these values the file spans pages 0 and 1, so page 2 lies outside it and shows the dropped-write and zero-read behaviour. Page values with bits set above bit 9 show the truncation. Back-to-back low-half write then high-half write, and low-half read then high-half read, test the one-cycle forwarding through staging and the latched high half. A write placed between a low-half read and its high-half read shows that the latched value is kept.

// File: rtl/mpb_pkg.sv
package mpb_pkg;
  typedef enum logic [2:0] {
    OP_NONE,
    OP_PAGE_WR,
    OP_LOW_WR,
    OP_HIGH_WR,
    OP_LOW_RD,
    OP_HIGH_RD,
    OP_PAGE_RD,
    OP_ZERO_RD
  } op_e;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_LOW,
    RK_HIGH,
    RK_PAGE,
    RK_ZERO
  } rd_kind_e;

  localparam logic [4:0] REG_HIGH = 5'h10;
  localparam logic [4:0] REG_PAGE = 5'h1F;
endpackage

// File: rtl/mpb_decode.sv
module mpb_decode
  import mpb_pkg::*;
#(
  parameter logic [4:0] BRIDGE_PHY = 5'h1F
) (
  input  logic       valid_i,
  input  logic       write_i,
  input  logic [4:0] phy_i,
  input  logic [4:0] reg_i,
  output op_e        op_o
);
  logic hit;
  assign hit = valid_i && (phy_i == BRIDGE_PHY);

  always_comb begin
    op_o = OP_NONE;
    if (hit) begin
      if (!reg_i[4]) begin
        op_o = write_i ? OP_LOW_WR : OP_LOW_RD;
      end else if (reg_i == REG_HIGH) begin
        op_o = write_i ? OP_HIGH_WR : OP_HIGH_RD;
      end else if (reg_i == REG_PAGE) begin
        op_o = write_i ? OP_PAGE_WR : OP_PAGE_RD;
      end else begin
        op_o = write_i ? OP_NONE : OP_ZERO_RD;
      end
    end
  end
endmodule

// File: rtl/mpb_stage.sv
module mpb_stage
  import mpb_pkg::*;
#(
  parameter int PAGE_W = 10,
  localparam int ADDR_W = PAGE_W + 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  op_e               op_i,
  input  logic [3:0]        idx_i,
  input  logic [15:0]       wdata_i,
  input  logic [31:0]       bus_rdata_i,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [31:0]       bus_wdata_o,
  output logic              rsp_valid_o,
  output logic [15:0]       rsp_rdata_o
);
  logic [PAGE_W-1:0] page_q;
  logic [15:0]       low_q;
  logic [3:0]        widx_q;
  logic [15:0]       hi_q;
  rd_kind_e          kind_q;

  // request stage: page, staging, bus cycle launch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q      <= '0;
      low_q       <= '0;
      widx_q      <= '0;
      bus_req_o   <= 1'b0;
      bus_we_o    <= 1'b0;
      bus_addr_o  <= '0;
      bus_wdata_o <= '0;
      kind_q      <= RK_NONE;
    end else begin
      bus_req_o <= 1'b0;
      bus_we_o  <= 1'b0;
      kind_q    <= RK_NONE;
      unique case (op_i)
        OP_PAGE_WR: page_q <= wdata_i[PAGE_W-1:0];
        OP_LOW_WR: begin
          low_q  <= wdata_i;
          widx_q <= idx_i;
        end
        OP_HIGH_WR: begin
          bus_req_o   <= 1'b1;
          bus_we_o    <= 1'b1;
          bus_addr_o  <= {page_q, widx_q, 2'b00};
          bus_wdata_o <= {wdata_i, low_q};
        end
        OP_LOW_RD: begin
          bus_req_o  <= 1'b1;
          bus_addr_o <= {page_q, idx_i, 2'b00};
          kind_q     <= RK_LOW;
        end
        OP_HIGH_RD: kind_q <= RK_HIGH;
        OP_PAGE_RD: kind_q <= RK_PAGE;
        OP_ZERO_RD: kind_q <= RK_ZERO;
        default: ;
      endcase
    end
  end

  // response stage: bus data returns combinationally during the cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
      hi_q        <= '0;
    end else begin
      rsp_valid_o <= (kind_q != RK_NONE);
      unique case (kind_q)
        RK_LOW: begin
          rsp_rdata_o <= bus_rdata_i[15:0];
          hi_q        <= bus_rdata_i[31:16];
        end
        RK_HIGH: rsp_rdata_o <= hi_q;
        RK_PAGE: rsp_rdata_o <= 16'(page_q);
        RK_ZERO: rsp_rdata_o <= '0;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mpb_regfile.sv
module mpb_regfile #(
  parameter int ADDR_W = 16,
  parameter int RF_AW  = 5,
  localparam int WORDS = 1 << RF_AW,
  localparam int TAG_W = ADDR_W - 2 - RF_AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o
);
  logic [31:0]      mem_q [WORDS];
  logic             hit;
  logic [RF_AW-1:0] idx;

  assign idx = addr_i[2 +: RF_AW];
  assign hit = (addr_i[ADDR_W-1 -: TAG_W] == '0) && (addr_i[1:0] == 2'b00);
  assign rdata_o = (req_i && hit) ? mem_q[idx] : 32'h0;

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_q[g] <= '0;
      end else if (req_i && we_i && hit && (idx == RF_AW'(g))) begin
        mem_q[g] <= wdata_i;
      end
    end
  end
endmodule

// File: rtl/mdio_page_bridge.sv
module mdio_page_bridge
  import mpb_pkg::*;
#(
  parameter logic [4:0] BRIDGE_PHY = 5'h1F,
  parameter int         PAGE_W     = 10,
  parameter int         RF_AW      = 5,
  localparam int        ADDR_W     = PAGE_W + 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [4:0]        req_phy_i,
  input  logic [4:0]        req_reg_i,
  input  logic [15:0]       req_wdata_i,
  output logic              rsp_valid_o,
  output logic [15:0]       rsp_rdata_o,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [31:0]       bus_wdata_o
);
  op_e         op;
  logic [31:0] bus_rdata;

  mpb_decode #(.BRIDGE_PHY(BRIDGE_PHY)) u_decode (
    .valid_i (req_valid_i),
    .write_i (req_write_i),
    .phy_i   (req_phy_i),
    .reg_i   (req_reg_i),
    .op_o    (op)
  );

  mpb_stage #(.PAGE_W(PAGE_W)) u_stage (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .op_i        (op),
    .idx_i       (req_reg_i[3:0]),
    .wdata_i     (req_wdata_i),
    .bus_rdata_i (bus_rdata),
    .bus_req_o   (bus_req_o),
    .bus_we_o    (bus_we_o),
    .bus_addr_o  (bus_addr_o),
    .bus_wdata_o (bus_wdata_o),
    .rsp_valid_o (rsp_valid_o),
    .rsp_rdata_o (rsp_rdata_o)
  );

  mpb_regfile #(.ADDR_W(ADDR_W), .RF_AW(RF_AW)) u_regfile (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (bus_req_o),
    .we_i    (bus_we_o),
    .addr_i  (bus_addr_o),
    .wdata_i (bus_wdata_o),
    .rdata_o (bus_rdata)
  );
endmodule

// File: rtl/mpb_checks.sv
module mpb_checks #(
  parameter logic [4:0] BRIDGE_PHY = 5'h1F,
  parameter int         ADDR_W     = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_write_i,
  input logic [4:0]        req_phy_i,
  input logic [4:0]        req_reg_i,
  input logic              rsp_valid_o,
  input logic              bus_req_o,
  input logic              bus_we_o,
  input logic [ADDR_W-1:0] bus_addr_o
);
  logic mine, foreign, rd_any;
  assign mine    = req_valid_i && (req_phy_i == BRIDGE_PHY);
  assign foreign = req_valid_i && (req_phy_i != BRIDGE_PHY);
  assign rd_any  = mine && !req_write_i;

  a_r7_word_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> (bus_addr_o[1:0] == 2'b00));

  a_r1_foreign_no_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    foreign |=> !bus_req_o);

  a_r3_low_write_no_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mine && req_write_i && !req_reg_i[4]) |=> !bus_req_o);

  a_r4_high_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mine && req_write_i && req_reg_i == 5'h10) |=> (bus_req_o && bus_we_o));

  a_r5_low_read_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mine && !req_write_i && !req_reg_i[4]) |=> (bus_req_o && !bus_we_o));

  a_r8_reserved_write_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mine && req_write_i && req_reg_i[4] && req_reg_i != 5'h10 && req_reg_i != 5'h1F)
      |=> !bus_req_o);

  a_r11_rsp_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(rd_any, 2));

  a_r11_rsp_follows_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_any, 2) |-> rsp_valid_o);
endmodule

bind mdio_page_bridge mpb_checks #(.BRIDGE_PHY(BRIDGE_PHY), .ADDR_W(ADDR_W)) u_checks (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_write_i (req_write_i),
  .req_phy_i   (req_phy_i),
  .req_reg_i   (req_reg_i),
  .rsp_valid_o (rsp_valid_o),
  .bus_req_o   (bus_req_o),
  .bus_we_o    (bus_we_o),
  .bus_addr_o  (bus_addr_o)
);

// File: tb/mdio_page_bridge_tb.sv
module mdio_page_bridge_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] PHY = 5'h1F;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_write_i = 1'b0;
  logic [4:0]  req_phy_i = '0;
  logic [4:0]  req_reg_i = '0;
  logic [15:0] req_wdata_i = '0;
  logic        rsp_valid_o;
  logic [15:0] rsp_rdata_o;
  logic        bus_req_o;
  logic        bus_we_o;
  logic [15:0] bus_addr_o;
  logic [31:0] bus_wdata_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] model [int];
  logic [15:0] page_m = '0;
  logic [15:0] hi_m   = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  mdio_page_bridge u_dut (
    .clk_i, .rst_ni, .req_valid_i, .req_write_i, .req_phy_i, .req_reg_i,
    .req_wdata_i, .rsp_valid_o, .rsp_rdata_o, .bus_req_o, .bus_we_o,
    .bus_addr_o, .bus_wdata_o
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: compares each response against the scoreboard queue
  always @(negedge clk_i) begin
    if (rst_ni && rsp_valid_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R11 unexpected response", 32'(rsp_rdata_o), 32'h0);
      end else begin
        automatic logic [15:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(rsp_rdata_o == e, t, 32'(rsp_rdata_o), 32'(e));
      end
    end
  end

  function automatic logic [31:0] mem_rd(input logic [15:0] a);
    if (a < 16'h0080 && model.exists(int'(a))) return model[int'(a)];
    return 32'h0;
  endfunction

  // one request cycle; returns at the negedge where its bus cycle is visible
  task automatic op(input bit w, input logic [4:0] phy, input logic [4:0] r,
                    input logic [15:0] d);
    req_valid_i = 1'b1;
    req_write_i = w;
    req_phy_i   = phy;
    req_reg_i   = r;
    req_wdata_i = d;
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  task automatic expect_rsp(input logic [15:0] v, input string t);
    exp_q.push_back(v);
    tag_q.push_back(t);
  endtask

  task automatic write_word(input logic [15:0] pg, input logic [3:0] idx,
                            input logic [31:0] d);
    logic [15:0] a;
    op(1'b1, PHY, 5'h1F, pg);
    page_m = pg & 16'h03FF;
    op(1'b1, PHY, {1'b0, idx}, d[15:0]);
    chk(!bus_req_o, "R3 low write starts no bus cycle", 32'(bus_req_o), 0);
    op(1'b1, PHY, 5'h10, d[31:16]);
    a = {page_m[9:0], idx, 2'b00};
    chk(bus_req_o && bus_we_o, "R4 high write commits", {bus_req_o, bus_we_o}, 2'b11);
    chk(bus_addr_o == a, "R4 R7 commit address", 32'(bus_addr_o), 32'(a));
    chk(bus_wdata_o == d, "R4 commit data", bus_wdata_o, d);
    if (a < 16'h0080) model[int'(a)] = d;
  endtask

  task automatic read_word(input logic [15:0] pg, input logic [3:0] idx, input string t);
    logic [15:0] a;
    logic [31:0] w;
    op(1'b1, PHY, 5'h1F, pg);
    page_m = pg & 16'h03FF;
    a = {page_m[9:0], idx, 2'b00};
    w = mem_rd(a);
    op(1'b0, PHY, {1'b0, idx}, 16'h0);
    expect_rsp(w[15:0], {t, " R5 low half"});
    hi_m = w[31:16];
    chk(bus_req_o && !bus_we_o && bus_addr_o == a, "R5 R7 read cycle address",
        32'(bus_addr_o), 32'(a));
    op(1'b0, PHY, 5'h10, 16'h0);
    expect_rsp(hi_m, {t, " R6 high half"});
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!rsp_valid_o && !bus_req_o, "R9 reset outputs idle",
        {rsp_valid_o, bus_req_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R9 / R6 reset values
    op(1'b0, PHY, 5'h1F, 0);
    expect_rsp(16'h0000, "R9 page after reset");
    op(1'b0, PHY, 5'h10, 0);
    expect_rsp(16'h0000, "R6 high latch after reset");

    // R11 latency: one negedge after request no rsp, next one rsp
    repeat (3) @(negedge clk_i);
    op(1'b0, PHY, 5'h1F, 0);
    expect_rsp(16'h0000, "R11 page read data");
    chk(!rsp_valid_o, "R11 no response after one edge", 32'(rsp_valid_o), 0);
    @(negedge clk_i);
    chk(rsp_valid_o, "R11 response after two edges", 32'(rsp_valid_o), 1);
    @(negedge clk_i);
    chk(!rsp_valid_o, "R11 single cycle pulse", 32'(rsp_valid_o), 0);

    // R4 R5 basic word traffic
    write_word(16'h0000, 4'd3, 32'hDEADBEEF);
    read_word(16'h0000, 4'd3, "word p0 i3");
    write_word(16'h0001, 4'd15, 32'h12345678);
    write_word(16'h0001, 4'd0, 32'hA5A55A5A);
    read_word(16'h0001, 4'd15, "word p1 i15");
    read_word(16'h0001, 4'd0, "word p1 i0");

    // R2 page truncation
    op(1'b1, PHY, 5'h1F, 16'hFC01);
    op(1'b0, PHY, 5'h1F, 0);
    expect_rsp(16'h0001, "R2 page keeps bits 9:0");
    page_m = 16'h0001;

    // R1 foreign PHY requests ignored
    op(1'b1, 5'h03, 5'h1F, 16'h0002);
    op(1'b1, 5'h03, 5'h10, 16'hFFFF);
    chk(!bus_req_o, "R1 foreign write no bus", 32'(bus_req_o), 0);
    op(1'b0, 5'h1E, 5'h00, 0);
    chk(!bus_req_o, "R1 foreign read no bus", 32'(bus_req_o), 0);
    op(1'b0, PHY, 5'h1F, 0);
    expect_rsp(16'h0001, "R1 page unchanged by foreign write");

    // R8 reserved registers
    op(1'b1, PHY, 5'h15, 16'hBEEF);
    chk(!bus_req_o, "R8 reserved write no bus", 32'(bus_req_o), 0);
    op(1'b0, PHY, 5'h15, 0);
    expect_rsp(16'h0000, "R8 reserved read zero");
    op(1'b0, PHY, 5'h1F, 0);
    expect_rsp(16'h0001, "R8 page unchanged by reserved write");

    // R3 low write alone leaves memory untouched
    op(1'b1, PHY, 5'h1F, 16'h0000);
    op(1'b1, PHY, 5'h03, 16'h1111);
    chk(!bus_req_o, "R3 lone low write", 32'(bus_req_o), 0);
    read_word(16'h0000, 4'd3, "R3 memory unchanged");

    // R10 outside window
    write_word(16'h0002, 4'd1, 32'hCAFEF00D);
    read_word(16'h0002, 4'd1, "R10 outside window reads zero");
    read_word(16'h0000, 4'd1, "R10 in-window alias untouched");

    // R6 latched half survives an intervening write
    op(1'b1, PHY, 5'h1F, 16'h0001);
    op(1'b0, PHY, 5'h0F, 0);
    expect_rsp(16'h5678, "R6 low of latched word");
    op(1'b1, PHY, 5'h0F, 16'h0000);
    op(1'b1, PHY, 5'h10, 16'h9999);
    model[int'(16'h007C)] = 32'h99990000;
    op(1'b0, PHY, 5'h10, 0);
    expect_rsp(16'h1234, "R6 latch held across write");
    read_word(16'h0001, 4'd15, "R6 new value after refetch");

    repeat (4) @(negedge clk_i);
    chk(exp_q.size() == 0, "R11 all responses arrived", exp_q.size(), 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule